// File: doc/BRIEF.md
# Four-Entry Sample Queue with Sticky Error Flags

This block sits between an analog-to-digital converter and a processor. Each 12-bit conversion result is pushed into a small first-in-first-out store. Software pops the oldest result with a read strobe and sees it zero-extended on a 32-bit read port. A status word reports how full the store is. It also carries two sticky error flags: one for a write the store could not take, and one for a read made when the store held nothing. Software may also push its own dummy results, which lets code be developed without live conversions.

A 2-bit command register sets the interface mode. The command values are 0 for disable, 1 for enable and 3 for flush. The value 2 is not supported and behaves as disable. A small controller holds one of three named states:

- `ST_OFF`: the interface is disabled.
- `ST_ON`: converter results are accepted.
- `ST_HOLD`: the store has been flushed and the controller waits for a new mode.

Every command write chooses the next state. Writing 1 goes to `ST_ON`. Writing 0 or 2 goes to `ST_OFF`. Writing 3 goes to `ST_HOLD` and, in that same clock edge, empties the store and clears both sticky flags. These transitions apply from any state.

Once an error flag is set, it freezes the pointer it guards until the next flush. After an overflow, no further writes are accepted. After an underflow, reads keep returning the last result that was actually popped.

Top module: `smpl_queue`

## Requirements
- R1: After reset the status word is 0x00000001 (only the empty flag set), the read port is 0 and the command readback is 0.
- R2: Results pop in the order they were pushed; the read port shows the popped 12-bit result zero-extended to 32 bits in the cycle after the read strobe, and status bits 31:5 are always 0.
- R3: Status bit 1 (almost full) is 1 exactly when three results are held; status bit 2 (full) is 1 exactly when four are held; the two are never 1 together; status bit 0 (empty) is 1 exactly when none are held.
- R4: A push attempted while full is dropped and sets status bit 4 (overflow); overflow stays set until a flush and, while set, no push is accepted even after reads have made room.
- R5: A read strobe while empty leaves the read port unchanged and sets status bit 3 (underflow); underflow stays set until a flush and, while set, reads neither pop nor change the read port, even if results are pushed.
- R6: A dummy push (dummy_wr_en) is accepted in every controller state, and when it coincides with a converter result the dummy value is stored and the converter result is discarded.
- R7: Converter results (conv_valid) are accepted only in ST_ON, which is entered by writing command 1; in ST_OFF they are discarded.
- R8: Writing command 3 empties the store and clears overflow and underflow at that clock edge, so the status reads 0x00000001 afterwards; the command readback returns the last value written, including the unsupported value 2.
- R9: After a flush the controller sits in ST_HOLD, where converter results are discarded until command 1 is written.
- R10: A read and a push in the same cycle, with the store neither empty nor full, leave the fill level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 2 | Command value: 0 disable, 1 enable, 3 flush |
| cmd_rd | output | 2 | Command register readback |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result |
| dummy_wr_en | input | 1 | Software dummy-result write strobe |
| dummy_data | input | 12 | Software dummy result |
| data_rd_en | input | 1 | Software read strobe (pops oldest result) |
| rd_data | output | 32 | Last popped result, zero-extended |
| status | output | 32 | Bit 0 empty, 1 almost full, 2 full, 3 underflow, 4 overflow, rest 0 |

## Verification
The bench builds the block with its default parameters: a 12-bit result width and a depth of four. With a depth this small, the store becomes full after four pushes and almost full after three. The overflow and underflow freezes can then be reached and escaped within a few cycles of each scenario. The 12-bit width lets the test patterns use the all-ones value 0xFFF, which shows that the zero extension to 32 bits stops exactly at bit 12.

// File: rtl/smpl_queue_pkg.sv
package smpl_queue_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_e;

    localparam logic [1:0] CMD_DIS   = 2'd0;
    localparam logic [1:0] CMD_EN    = 2'd1;
    localparam logic [1:0] CMD_FLUSH = 2'd3;

    localparam int ST_BIT_EMPTY = 0;
    localparam int ST_BIT_AFULL = 1;
    localparam int ST_BIT_FULL  = 2;
    localparam int ST_BIT_UNF   = 3;
    localparam int ST_BIT_OVF   = 4;
    localparam int ST_USED      = 5;

    localparam int BUS_W = 32;

endpackage

// File: rtl/smpl_queue_ctrl.sv
module smpl_queue_ctrl
    import smpl_queue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_en,
    input  logic [1:0] cmd_wr_data,
    output logic [1:0] cmd_q,
    output logic       conv_ok,
    output logic       flush_clr
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    // state register and command readback register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cmd_q   <= CMD_DIS;
        end else begin
            state_q <= state_d;
            if (cmd_wr_en) begin
                cmd_q <= cmd_wr_data;
            end
        end
    end

    // next state: every command write picks the new mode
    always_comb begin
        state_d = state_q;
        if (cmd_wr_en) begin
            unique case (cmd_wr_data)
                CMD_EN:    state_d = ST_ON;
                CMD_FLUSH: state_d = ST_HOLD;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        flush_clr = cmd_wr_en && (cmd_wr_data == CMD_FLUSH);
        unique case (state_q)
            ST_ON:   conv_ok = 1'b1;
            ST_HOLD: conv_ok = 1'b0;
            default: conv_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/smpl_queue_store.sv
module smpl_queue_store #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            push,
    input  logic [DATA_W-1:0]               push_data,
    input  logic                            pop,
    output logic [$clog2(DEPTH+1)-1:0]      count_o,
    output logic [DATA_W-1:0]               last_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] last_q;

    // one register per entry, written when the write pointer selects it
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (push && (wr_ptr_q == PTR_W'(gi))) begin
                mem_q[gi] <= push_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // the last popped result is kept across flushes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (pop) begin
            last_q <= mem_q[rd_ptr_q];
        end
    end

    assign count_o = count_q;
    assign last_o  = last_q;

endmodule

// File: rtl/smpl_queue_flags.sv
module smpl_queue_flags
    import smpl_queue_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push_req,
    input  logic                         pop_req,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic [ST_USED-1:0]           flags
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_AFULL = CNT_W'(DEPTH - 1);

    logic ovf_q;
    logic unf_q;
    logic full;
    logic empty;
    logic afull;

    assign full  = (count == CNT_FULL);
    assign empty = (count == '0);
    assign afull = (count == CNT_AFULL);

    // sticky flags freeze the pointer they guard
    assign push_ok = push_req && !full && !ovf_q && !clr;
    assign pop_ok  = pop_req && !empty && !unf_q && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else if (clr) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (push_req && full) begin
                ovf_q <= 1'b1;
            end
            if (pop_req && empty) begin
                unf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        flags               = '0;
        flags[ST_BIT_EMPTY] = empty;
        flags[ST_BIT_AFULL] = afull;
        flags[ST_BIT_FULL]  = full;
        flags[ST_BIT_UNF]   = unf_q;
        flags[ST_BIT_OVF]   = ovf_q;
    end

endmodule

// File: rtl/smpl_queue.sv
module smpl_queue
    import smpl_queue_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [1:0]        cmd_wr_data,
    output logic [1:0]        cmd_rd,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              dummy_wr_en,
    input  logic [DATA_W-1:0] dummy_data,
    input  logic              data_rd_en,
    output logic [BUS_W-1:0]  rd_data,
    output logic [BUS_W-1:0]  status
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              conv_ok;
    logic              flush_clr;
    logic              push_req;
    logic [DATA_W-1:0] push_data;
    logic              push_ok;
    logic              pop_ok;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] last;
    logic [ST_USED-1:0] flags;

    smpl_queue_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_en   (cmd_wr_en),
        .cmd_wr_data (cmd_wr_data),
        .cmd_q       (cmd_rd),
        .conv_ok     (conv_ok),
        .flush_clr   (flush_clr)
    );

    // the software write wins over a coincident converter result
    assign push_req  = dummy_wr_en || (conv_valid && conv_ok);
    assign push_data = dummy_wr_en ? dummy_data : conv_data;

    smpl_queue_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush_clr),
        .push_req (push_req),
        .pop_req  (data_rd_en),
        .count    (count),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .flags    (flags)
    );

    smpl_queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush_clr),
        .push      (push_ok),
        .push_data (push_data),
        .pop       (pop_ok),
        .count_o   (count),
        .last_o    (last)
    );

    assign rd_data = {{(BUS_W-DATA_W){1'b0}}, last};
    assign status  = {{(BUS_W-ST_USED){1'b0}}, flags};

endmodule

// File: rtl/smpl_queue_chk.sv
module smpl_queue_chk #(
    parameter int DATA_W = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr_en,
    input logic [1:0]  cmd_wr_data,
    input logic [1:0]  cmd_rd,
    input logic        conv_valid,
    input logic        dummy_wr_en,
    input logic        data_rd_en,
    input logic [31:0] rd_data,
    input logic [31:0] status
);

    logic flush;
    assign flush = cmd_wr_en && (cmd_wr_data == 2'd3);

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31:5] == '0) && (rd_data[31:DATA_W] == '0));

    assert_afull_full_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]));

    assert_full_push_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] && (dummy_wr_en || conv_valid) && !data_rd_en && !flush
        |=> status[2] && status[4]);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] && !flush |=> status[4]);

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && data_rd_en && !flush |=> $stable(rd_data) && status[3]);

    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] && !flush |=> status[3]);

    assert_conv_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && conv_valid && !dummy_wr_en && (cmd_rd != 2'd1) && !cmd_wr_en
        |=> status[0]);

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status[4:0] == 5'b00001));

    assert_cmd_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_en |=> (cmd_rd == $past(cmd_wr_data)));

endmodule

bind smpl_queue smpl_queue_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wr_data (cmd_wr_data),
    .cmd_rd      (cmd_rd),
    .conv_valid  (conv_valid),
    .dummy_wr_en (dummy_wr_en),
    .data_rd_en  (data_rd_en),
    .rd_data     (rd_data),
    .status      (status)
);

// File: tb/smpl_queue_tb_top.sv
module smpl_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [1:0]  cmd_wr_data = '0;
    logic [1:0]  cmd_rd;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;
    logic        dummy_wr_en = 1'b0;
    logic [11:0] dummy_data = '0;
    logic        data_rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] status;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    smpl_queue dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_en   (cmd_wr_en),
        .cmd_wr_data (cmd_wr_data),
        .cmd_rd      (cmd_rd),
        .conv_valid  (conv_valid),
        .conv_data   (conv_data),
        .dummy_wr_en (dummy_wr_en),
        .dummy_data  (dummy_data),
        .data_rd_en  (data_rd_en),
        .rd_data     (rd_data),
        .status      (status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one clock edge, then sample 1 ns later and release strobes
    task automatic step();
        @(posedge clk);
        #1;
        cmd_wr_en   = 1'b0;
        conv_valid  = 1'b0;
        dummy_wr_en = 1'b0;
        data_rd_en  = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] v);
        cmd_wr_en = 1'b1; cmd_wr_data = v; step();
    endtask

    task automatic do_conv(input logic [11:0] d);
        conv_valid = 1'b1; conv_data = d; step();
    endtask

    task automatic do_dummy(input logic [11:0] d);
        dummy_wr_en = 1'b1; dummy_data = d; step();
    endtask

    task automatic do_read();
        data_rd_en = 1'b1; step();
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h1);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 cmd", {30'b0, cmd_rd}, 32'h0);
    endtask

    task automatic t_order();
        do_cmd(2'd1);
        do_conv(12'hABC);
        do_conv(12'h123);
        do_conv(12'hFFF);
        chk("R3 almost full at three", status, 32'h2);
        do_conv(12'h001);
        chk("R3 full at four", status, 32'h4);
        do_read(); chk("R2 first", rd_data, 32'hABC);
        do_read(); chk("R2 second", rd_data, 32'h123);
        do_read(); chk("R2 zero extend", rd_data, 32'h0000_0FFF);
        do_read(); chk("R2 fourth", rd_data, 32'h001);
        chk("R3 empty again", status, 32'h1);
    endtask

    task automatic t_overflow();
        do_cmd(2'd3);
        do_cmd(2'd1);
        for (int i = 1; i <= 4; i++) do_conv(12'h100 + 12'(i));
        do_conv(12'h105);
        chk("R4 overflow set", status, 32'h14);
        do_read();
        chk("R4 oldest kept", rd_data, 32'h101);
        chk("R4 sticky after read", status, 32'h12);
        do_dummy(12'h106);
        chk("R4 push blocked", status, 32'h12);
        do_read(); do_read(); do_read();
        chk("R4 no extra entry", rd_data, 32'h104);
        chk("R4 empty with overflow", status, 32'h11);
        do_cmd(2'd3);
        chk("R8 flush clears overflow", status, 32'h1);
    endtask

    task automatic t_underflow();
        do_cmd(2'd1);
        do_conv(12'h2AA);
        do_read();
        chk("R5 normal read", rd_data, 32'h2AA);
        do_read();
        chk("R5 repeat value", rd_data, 32'h2AA);
        chk("R5 underflow set", status, 32'h9);
        do_conv(12'h055);
        chk("R5 sticky with data", status, 32'h8);
        do_read();
        chk("R5 read frozen", rd_data, 32'h2AA);
        chk("R5 entry not popped", status, 32'h8);
        do_cmd(2'd3);
        chk("R8 flush clears underflow", status, 32'h1);
    endtask

    task automatic t_gate();
        do_cmd(2'd0);
        do_conv(12'h777);
        chk("R7 disabled drops", status, 32'h1);
        do_cmd(2'd2);
        chk("R8 readback of 2", {30'b0, cmd_rd}, 32'h2);
        do_conv(12'h778);
        chk("R7 value 2 drops", status, 32'h1);
        do_cmd(2'd3);
        chk("R8 readback of 3", {30'b0, cmd_rd}, 32'h3);
        do_conv(12'h779);
        chk("R9 hold drops", status, 32'h1);
        do_dummy(12'h3C3);
        chk("R6 dummy in hold", status, 32'h0);
        do_read();
        chk("R6 dummy value", rd_data, 32'h3C3);
        do_cmd(2'd1);
        do_conv(12'h5A5);
        chk("R7 enabled accepts", status, 32'h0);
        do_read();
        chk("R7 value", rd_data, 32'h5A5);
    endtask

    task automatic t_priority();
        dummy_wr_en = 1'b1; dummy_data = 12'h0D0;
        conv_valid  = 1'b1; conv_data  = 12'h0C0;
        step();
        do_read();
        chk("R6 dummy wins", rd_data, 32'h0D0);
        chk("R6 single entry", status, 32'h1);
    endtask

    task automatic t_simul();
        do_conv(12'h011);
        do_conv(12'h022);
        data_rd_en = 1'b1; conv_valid = 1'b1; conv_data = 12'h033;
        step();
        chk("R10 read during push", rd_data, 32'h011);
        chk("R10 level kept", status, 32'h0);
        do_read();
        chk("R10 order second", rd_data, 32'h022);
        do_read();
        chk("R10 order third", rd_data, 32'h033);
        chk("R10 empty", status, 32'h1);
    endtask

    initial begin
        #(4 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_overflow();
        t_underflow();
        t_gate();
        t_priority();
        t_simul();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule